// File: doc/BRIEF.md
# Four-Channel Output Compare PWM

This block holds four compare channels that watch one shared 16-bit timer count. The timer itself sits outside the block: its current value, its counting direction and a one-cycle pulse marking its reload are inputs. Every channel keeps its own compare value and has its own enable, polarity and interrupt-enable bits. When the count reaches a channel's compare value, the channel raises a sticky flag. If that channel's interrupt enable is set, it also raises an interrupt request.

Each channel also drives a PWM output. In edge-aligned form the timer counts up from zero to a period end and then reloads. In center-aligned form the timer counts up and then back down. A compare value written by software first lands in a shadow register. It moves into the working register only on the timer reload, so a period in progress never sees a half-changed threshold. Polarity is applied at the very end. A disabled channel therefore sits at the level its polarity bit defines as inactive.

Top module: `cmp_pwm_quad`

## Requirements
- R1: The four channels (select codes 0..3 on `wr_sel`) are independent: a write with `wr_en`=1 changes only the selected channel's shadow compare value, and each channel matches against its own working value.
- R2: A channel whose `ch_en` bit is 0 never sets its flag. Its `pwm_out` bit equals its `ch_pol` bit from the same cycle the enable drops, and its internal level is cleared at the next clock edge.
- R3: An enabled channel whose working compare value equals `tmr_val` at a clock edge has its `cmp_flag` bit set after that edge. The flag holds until a clock edge with its `flag_clr` bit at 1. A match and a clear at the same edge leave the flag set.
- R4: `irq_req[i]` is 1 exactly when `cmp_flag[i]` and `ch_ie[i]` are both 1.
- R5: `pwm_out[i]` is the channel's internal level XOR `ch_pol[i]`. With polarity 0 the output is active high; with polarity 1 it is inverted.
- R6: With `sym_mode`=0 (edge-aligned), an enabled channel's level becomes 1 after an edge that samples `tmr_val`=0 and becomes 0 after an edge that samples a match. A match takes priority, so a compare value of 0 keeps the level at 0. Otherwise the level holds.
- R7: With `sym_mode`=1 (center-aligned), a match with `tmr_down`=0 sets the level to 1 and a match with `tmr_down`=1 sets it to 0. Otherwise the level holds.
- R8: Writes go to a shadow register. The working compare value takes the shadow value at the clock edge where `tmr_reload`=1. A write in that same cycle stays in the shadow until the next reload.
- R9: After reset all shadow and working compare values, flags and levels are 0, so `pwm_out` equals `ch_pol` and `cmp_flag` and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | 16 | Current shared timer count |
| tmr_down | input | 1 | Timer direction, 1 = counting down |
| tmr_reload | input | 1 | One-cycle pulse at the timer reload point |
| sym_mode | input | 1 | 0 = edge-aligned PWM, 1 = center-aligned PWM |
| ch_en | input | 4 | Per-channel enable |
| ch_pol | input | 4 | Per-channel output inversion |
| ch_ie | input | 4 | Per-channel interrupt enable |
| flag_clr | input | 4 | Per-channel flag clear strobe |
| wr_en | input | 1 | Compare value write strobe |
| wr_sel | input | 2 | Channel selected by the write |
| wr_data | input | 16 | Compare value to write |
| pwm_out | output | 4 | PWM outputs after polarity |
| cmp_flag | output | 4 | Sticky match flags |
| irq_req | output | 4 | Interrupt requests |

## Verification
The bench runs full timer periods in both PWM forms with compare values of 0, a mid value, the last count of the period and a value past the period end. These expose an off-by-one at either end of the duty range, as well as a zero compare that wrongly glitches the output high. Writes are placed mid-period and in the same cycle as a reload. A design without double buffering would change the duty inside a period, and one that bypasses the shadow on a same-cycle write would take the new value one period early. The bench also times a flag clear to coincide with a match, which catches a clear that wins over a set. It disables one channel and checks that the other channels are unaffected, that the disabled output rests at its polarity level and that its flag stays clear.

// File: rtl/cmp_pwm_pkg.sv
package cmp_pwm_pkg;

    // PWM form selected by sym_mode
    typedef enum logic {
        FORM_EDGE   = 1'b0,
        FORM_CENTER = 1'b1
    } pwm_form_e;

    // Registered per-channel state
    typedef struct packed {
        logic flag;
        logic level;
    } chan_state_t;

endpackage

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_val,
    input  logic         reload,
    output logic [W-1:0] act_o
);

    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] act;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the working copy takes the value the shadow held before this edge
        if (reload) st_d.act = st_q.sh;
        if (wr_hit) st_d.sh  = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

    a_r8_hold_between_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(st_q.act));

    a_r8_load_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.act == $past(st_q.sh)));

endmodule

// File: rtl/cmp_chan_core.sv
module cmp_chan_core
    import cmp_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  pwm_form_e    form,
    input  logic         down,
    input  logic [W-1:0] tmr,
    input  logic [W-1:0] cmp_val,
    input  logic         clr,
    input  logic         pol,
    input  logic         ie,
    output logic         pwm,
    output logic         flag,
    output logic         irq
);

    chan_state_t st_d, st_q;
    logic        match;
    logic        at_zero;

    always_comb begin
        match   = en && (tmr == cmp_val);
        at_zero = (tmr == '0);
        st_d    = st_q;

        // set has priority over clear
        st_d.flag = (st_q.flag & ~clr) | match;

        if (!en) begin
            st_d.level = 1'b0;
        end else if (form == FORM_CENTER) begin
            if (match) st_d.level = !down;
        end else begin
            if (match)        st_d.level = 1'b0;
            else if (at_zero) st_d.level = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm  = (en & st_q.level) ^ pol;
    assign flag = st_q.flag;
    assign irq  = st_q.flag & ie;

    a_r3_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.flag);

    a_r3_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(match));

    a_r2_off_clears_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.level);

    a_r6_edge_match_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en && form == FORM_EDGE && tmr == cmp_val) |=> !st_q.level);

    a_r7_center_up_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en && form == FORM_CENTER && !down && tmr == cmp_val) |=> st_q.level);

    a_r7_center_down_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en && form == FORM_CENTER && down && tmr == cmp_val) |=> !st_q.level);

endmodule

// File: rtl/cmp_pwm_quad.sv
module cmp_pwm_quad
    import cmp_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int W      = 16,
    localparam int SELW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      tmr_val,
    input  logic              tmr_down,
    input  logic              tmr_reload,
    input  logic              sym_mode,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_pol,
    input  logic [NUM_CH-1:0] ch_ie,
    input  logic [NUM_CH-1:0] flag_clr,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [W-1:0]      wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] cmp_flag,
    output logic [NUM_CH-1:0] irq_req
);

    pwm_form_e         form;
    logic [NUM_CH-1:0] wr_hit;

    assign form = sym_mode ? FORM_CENTER : FORM_EDGE;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [W-1:0] cmp_act;

        assign wr_hit[ch] = wr_en && (wr_sel == SELW'(ch));

        cmp_shadow #(.W(W)) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit[ch]),
            .wr_val (wr_data),
            .reload (tmr_reload),
            .act_o  (cmp_act)
        );

        cmp_chan_core #(.W(W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ch_en[ch]),
            .form    (form),
            .down    (tmr_down),
            .tmr     (tmr_val),
            .cmp_val (cmp_act),
            .clr     (flag_clr[ch]),
            .pol     (ch_pol[ch]),
            .ie      (ch_ie[ch]),
            .pwm     (pwm_out[ch]),
            .flag    (cmp_flag[ch]),
            .irq     (irq_req[ch])
        );
    end

    // R1: a single write strobe reaches at most one channel
    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit) && (wr_en == (wr_hit != '0)));

endmodule

// File: tb/cmp_pwm_quad_test.sv
module cmp_pwm_quad_test;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 8;
    localparam int W  = 16;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  tmr_val = '0;
    logic          tmr_down = 1'b0;
    logic          tmr_reload = 1'b0;
    logic          sym_mode = 1'b0;
    logic [NC-1:0] ch_en = '0;
    logic [NC-1:0] ch_pol = 4'b1010;
    logic [NC-1:0] ch_ie = '0;
    logic [NC-1:0] flag_clr = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [W-1:0]  wr_data = '0;
    logic [NC-1:0] pwm_out, cmp_flag, irq_req;

    int total = 0;
    int bad = 0;
    logic [W-1:0]  act_m [NC];
    logic [W-1:0]  sh_m  [NC];
    logic [NC-1:0] flag_m = '0;

    cmp_pwm_quad uut (
        .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .tmr_down(tmr_down),
        .tmr_reload(tmr_reload), .sym_mode(sym_mode), .ch_en(ch_en),
        .ch_pol(ch_pol), .ch_ie(ch_ie), .flag_clr(flag_clr), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out),
        .cmp_flag(cmp_flag), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // one clock: drive, take the edge, then check against the model
    task automatic step(input logic [W-1:0] v, input logic dn, input logic rl,
                        input logic [NC-1:0] clr, input logic wr,
                        input logic [1:0] wch, input logic [W-1:0] wv,
                        input string tag);
        logic [NC-1:0] exp_pwm;
        logic [NC-1:0] hit;
        tmr_val = v; tmr_down = dn; tmr_reload = rl; flag_clr = clr;
        wr_en = wr; wr_sel = wch; wr_data = wv;
        @(posedge clk);
        #1;
        for (int i = 0; i < NC; i++) begin
            logic raw;
            hit[i] = ch_en[i] && (v == act_m[i]);
            if (!ch_en[i])     raw = 1'b0;
            else if (sym_mode) raw = dn ? (v > act_m[i]) : (v >= act_m[i]);
            else               raw = (v < act_m[i]);
            exp_pwm[i] = raw ^ ch_pol[i];
        end
        flag_m = (flag_m & ~clr) | hit;
        if (rl) for (int i = 0; i < NC; i++) act_m[i] = sh_m[i];
        if (wr) sh_m[wch] = wv;
        chk({tag, " R5 pwm"}, W'(pwm_out), W'(exp_pwm));
        chk("R3 flag", W'(cmp_flag), W'(flag_m));
        chk("R4 irq", W'(irq_req), W'(flag_m & ch_ie));
        wr_en = 1'b0; flag_clr = '0; tmr_reload = 1'b0;
    endtask

    // edge-aligned: P steps; center-aligned: 2P steps
    task automatic run_period(input int clr_at, input logic [NC-1:0] clr_mask,
                              input int wr_at, input logic [1:0] wch,
                              input logic [W-1:0] wv, input string tag);
        int n;
        n = sym_mode ? 2*P : P;
        for (int k = 0; k < n; k++) begin
            logic [W-1:0] v;
            logic dn;
            if (k < P) begin v = W'(k); dn = 1'b0; end
            else begin v = W'(2*P-1-k); dn = 1'b1; end
            step(v, dn, (k == n-1), (k == clr_at) ? clr_mask : '0,
                 (k == wr_at), wch, wv, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        total++; bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin act_m[i] = '0; sh_m[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9 pwm", W'(pwm_out), W'(4'b1010));
        chk("R9 flag", W'(cmp_flag), '0);
        chk("R9 irq", W'(irq_req), '0);
        rst_n = 1'b1;

        // R2: disabled channels with count equal to reset compare 0
        step(0, 0, 0, '0, 1, 2'd0, 16'd0, "R2");
        step(5, 0, 0, '0, 1, 2'd1, 16'd3, "R2");
        step(5, 0, 0, '0, 1, 2'd2, 16'd7, "R2");
        step(5, 0, 0, '0, 1, 2'd3, 16'd8, "R2");
        step(P-1, 0, 1, '0, 0, 2'd0, 16'd0, "R2 R8");

        ch_en = 4'b1111; ch_ie = 4'b0110; sym_mode = 1'b0;
        // R1 R6: compares 0,3,7,8; write B=5 mid-period (R8: applies next period)
        run_period(-1, '0, 2, 2'd1, 16'd5, "R1 R6 R8");
        // clear all at v=4; write C=1 in the reload cycle (R8 same-cycle)
        run_period(4, 4'b1111, P-1, 2'd2, 16'd1, "R6 R8");
        // C still 7 this period
        run_period(-1, '0, -1, 2'd0, 16'd0, "R6 R8");
        // B disabled; C=1 now, clear C at v=1 together with its match (R3)
        ch_en = 4'b1101;
        run_period(1, 4'b0100, -1, 2'd0, 16'd0, "R2 R6");

        // all off for one step, then center-aligned
        ch_en = '0;
        step(3, 0, 0, 4'b1111, 0, 2'd0, 16'd0, "R2");
        ch_en = 4'b1111; ch_pol = 4'b0101; sym_mode = 1'b1;
        run_period(-1, '0, 5, 2'd3, 16'd4, "R7 R8");
        run_period(P, 4'b1111, -1, 2'd0, 16'd0, "R7");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule